// File: doc/BRIEF.md
# Hardwired Step-Sequenced Instruction Controller

This block generates the per-cycle strobes for a single-bus processor datapath. There is no stored control program. A small counter marks the current control step. A decoder turns that count into one-hot timing lines T1 to Tn. A second decoder turns the opcode field of the instruction register into one-hot instruction lines. Each strobe is then a sum of products of those step lines, those instruction lines and the negative condition flag.

Every instruction starts with three shared fetch steps:

- T1 places the PC on the bus and starts the read.
- T2 writes back PC plus four and waits for the memory-completed signal.
- T3 moves the fetched word into the instruction register.

After fetch the block runs one of four step sequences: a memory-operand add, an unconditional branch, a branch-if-negative, or a short sequence for any opcode it does not recognise. The end-of-instruction strobe sends the counter back to T1 on the next clock, so the next fetch begins at once. When the negative flag is clear, the branch-if-negative finishes one step early.

The surrounding datapath holds the opcode field and the flag stable. It raises the memory-completed input when a read finishes.

Top module: `hwired_ctrl_unit`

## Requirements
- R1: While `rst` is high (it is sampled synchronously), `ctrlBus` and `stepOneHot` are all zero. The first clock after `rst` falls shows T1 (`stepOneHot` = 1).
- R2: `stepOneHot` is one-hot, with bit k meaning step T(k+1). When the current step neither ends nor waits, the next clock moves to the following step. After the last step the counter wraps to T1.
- R3: `ctrlBus` bit positions are fixed as follows: 0 pcOut, 1 marIn, 2 memRead, 3 sel4, 4 aluAdd, 5 zIn, 6 zOut, 7 pcIn, 8 yIn, 9 waitMfc, 10 mdrOut, 11 irIn, 12 selY, 13 offOut, 14 regAOut, 15 regBOut, 16 regAIn, 17 endStep. At T1 exactly bits 0 to 5 are set, whatever the opcode.
- R4: At T2 exactly bits 6, 7, 8 and 9 are set. At T3 exactly bits 10 and 11 are set.
- R5: While waitMfc is set and `mfcIn` is low, the step is held and the strobes of that step repeat. The clock at which `mfcIn` is high advances the step.
- R6: For opcode 0 (add), the steps after fetch are as follows. T4 sets regBOut, marIn and memRead. T5 sets regAOut, yIn and waitMfc. T6 sets mdrOut, selY, aluAdd and zIn. T7 sets zOut, regAIn and endStep.
- R7: For opcode 1 (branch), T4 sets offOut, selY, aluAdd and zIn. T5 sets zOut, pcIn and endStep.
- R8: For opcode 2 (branch-if-negative) with `negFlag` high, T4 and T5 are the same as for opcode 1.
- R9: For opcode 2 with `negFlag` low, T4 sets the branch-address strobes together with endStep, and T5 is never reached.
- R10: Whenever endStep is set, the next clock shows T1.
- R11: Any other opcode sets only endStep at T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opField | input | OP_W | Opcode field held in the instruction register |
| negFlag | input | 1 | Negative condition code |
| mfcIn | input | 1 | Memory operation completed |
| ctrlBus | output | 18 | Datapath strobes (bit map in R3) |
| stepOneHot | output | NUM_STEPS | Current control step, one-hot |

## Verification
The two functions that can land in the same cycle are the computation of the branch target and the early end of the branch-if-negative. When the flag is clear, T4 both loads the target sum into Z and asserts endStep. The bench provokes this by running the branch-if-negative with the flag low, and also with the flag high for contrast. A behavioural model predicts the full strobe word on every clock and judges that T4 carries zIn and endStep together and that the next cycle is T1, not T5. Reset is also applied during a memory wait, to show that reset wins over the hold.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
  localparam int OP_ADD = 0;
  localparam int OP_BR  = 1;
  localparam int OP_BRN = 2;

  // packed: first field is the MSB, so pcOut lands on bit 0 and endStep on bit 17
  typedef struct packed {
    logic endStep;
    logic regAIn;
    logic regBOut;
    logic regAOut;
    logic offOut;
    logic selY;
    logic irIn;
    logic mdrOut;
    logic waitMfc;
    logic yIn;
    logic pcIn;
    logic zOut;
    logic zIn;
    logic aluAdd;
    logic sel4;
    logic memRead;
    logic marIn;
    logic pcOut;
  } ctrlStrobes_t;

  localparam int NUM_CTL = $bits(ctrlStrobes_t);

  typedef struct packed {
    logic isAdd;
    logic isBr;
    logic isBrn;
    logic isOther;
  } opLines_t;
endpackage

// File: rtl/hcu_step_gen.sv
module hcu_step_gen #(
  parameter int NUM_STEPS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 endIn,
  input  logic                 waitIn,
  input  logic                 mfcIn,
  output logic [NUM_STEPS-1:0] stepOh
);
  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] stepIdx;
  logic              holdStep;

  assign holdStep = waitIn && !mfcIn;

  always_ff @(posedge clk) begin
    if (rst)                    stepIdx <= '0;
    else if (endIn)             stepIdx <= '0;
    else if (holdStep)          stepIdx <= stepIdx;
    else if (stepIdx == LAST_IDX) stepIdx <= '0;
    else                        stepIdx <= stepIdx + STEP_W'(1);
  end

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tdec
    assign stepOh[g] = (stepIdx == STEP_W'(g));
  end

  p_step_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot(stepOh));

  p_end_restart_r10: assert property (@(posedge clk) disable iff (rst)
    endIn |=> stepOh[0]);

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (waitIn && !mfcIn && !endIn) |=> $stable(stepOh));

  p_step_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!endIn && !waitIn && stepIdx != LAST_IDX) |=> (stepIdx == $past(stepIdx) + STEP_W'(1)));
endmodule

// File: rtl/hcu_op_decode.sv
module hcu_op_decode
  import hcu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opField,
  output opLines_t        ops
);
  always_comb begin
    ops.isAdd   = (opField == OP_W'(OP_ADD));
    ops.isBr    = (opField == OP_W'(OP_BR));
    ops.isBrn   = (opField == OP_W'(OP_BRN));
    ops.isOther = !(ops.isAdd || ops.isBr || ops.isBrn);
  end
endmodule

// File: rtl/hcu_ctrl_encode.sv
module hcu_ctrl_encode
  import hcu_pkg::*;
#(
  parameter int NUM_STEPS = 8
) (
  input  logic [NUM_STEPS-1:0] stepOh,
  input  opLines_t             ops,
  input  logic                 negFlag,
  output ctrlStrobes_t         strobes
);
  logic t1, t2, t3, t4, t5, t6, t7;
  logic anyBranch;

  assign t1 = stepOh[0];
  assign t2 = stepOh[1];
  assign t3 = stepOh[2];
  assign t4 = stepOh[3];
  assign t5 = stepOh[4];
  assign t6 = stepOh[5];
  assign t7 = stepOh[6];
  assign anyBranch = ops.isBr || ops.isBrn;

  always_comb begin
    strobes.pcOut   = t1;
    strobes.marIn   = t1 | (t4 & ops.isAdd);
    strobes.memRead = t1 | (t4 & ops.isAdd);
    strobes.sel4    = t1;
    strobes.aluAdd  = t1 | (t6 & ops.isAdd) | (t4 & anyBranch);
    strobes.zIn     = t1 | (t6 & ops.isAdd) | (t4 & ops.isBr) | (t4 & ops.isBrn);
    strobes.zOut    = t2 | (t7 & ops.isAdd) | (t5 & anyBranch);
    strobes.pcIn    = t2 | (t5 & anyBranch);
    strobes.yIn     = t2 | (t5 & ops.isAdd);
    strobes.waitMfc = t2 | (t5 & ops.isAdd);
    strobes.mdrOut  = t3 | (t6 & ops.isAdd);
    strobes.irIn    = t3;
    strobes.selY    = (t6 & ops.isAdd) | (t4 & anyBranch);
    strobes.offOut  = t4 & anyBranch;
    strobes.regAOut = t5 & ops.isAdd;
    strobes.regBOut = t4 & ops.isAdd;
    strobes.regAIn  = t7 & ops.isAdd;
    strobes.endStep = (t7 & ops.isAdd) | (t5 & ops.isBr)
                    | (((t5 & negFlag) | (t4 & !negFlag)) & ops.isBrn)
                    | (t4 & ops.isOther);
  end
endmodule

// File: rtl/hwired_ctrl_unit.sv
module hwired_ctrl_unit
  import hcu_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int OP_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      opField,
  input  logic                 negFlag,
  input  logic                 mfcIn,
  output logic [NUM_CTL-1:0]   ctrlBus,
  output logic [NUM_STEPS-1:0] stepOneHot
);
  logic [NUM_STEPS-1:0] stepOh;
  opLines_t             ops;
  ctrlStrobes_t         strobes;

  hcu_step_gen #(.NUM_STEPS(NUM_STEPS)) u_step (
    .clk    (clk),
    .rst    (rst),
    .endIn  (strobes.endStep),
    .waitIn (strobes.waitMfc),
    .mfcIn  (mfcIn),
    .stepOh (stepOh)
  );

  hcu_op_decode #(.OP_W(OP_W)) u_opdec (
    .opField (opField),
    .ops     (ops)
  );

  hcu_ctrl_encode #(.NUM_STEPS(NUM_STEPS)) u_enc (
    .stepOh  (stepOh),
    .ops     (ops),
    .negFlag (negFlag),
    .strobes (strobes)
  );

  assign ctrlBus    = rst ? '0 : strobes;
  assign stepOneHot = rst ? '0 : stepOh;

  p_end_excl_wait_r10: assert property (@(posedge clk) disable iff (rst)
    !(strobes.endStep && strobes.waitMfc));

  p_fetch_head_r3: assert property (@(posedge clk) disable iff (rst)
    stepOneHot[0] |-> (ctrlBus[0] && ctrlBus[5] && !ctrlBus[17]));
endmodule

// File: tb/hwired_ctrl_unit_bench.sv
module hwired_ctrl_unit_bench;
  localparam int NS = 8;
  localparam int OW = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic [OW-1:0] opField = '0;
  logic          negFlag = 0;
  logic          mfcIn = 0;
  logic [17:0]   ctrlBus;
  logic [NS-1:0] stepOneHot;

  int vecCnt = 0, errCnt = 0, cyc = 0;
  int mStep = 1;          // model step, 1 = T1
  string mKind = "R1";    // why the model reached its current step
  int waitCnt = 0, latency = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hwired_ctrl_unit #(.NUM_STEPS(NS), .OP_W(OW)) u_hwired_ctrl_unit (
    .clk(clk), .rst(rst), .opField(opField), .negFlag(negFlag),
    .mfcIn(mfcIn), .ctrlBus(ctrlBus), .stepOneHot(stepOneHot));

  function automatic logic [17:0] bitsOf(input int a, b, c, d, e);
    logic [17:0] v = '0;
    if (a >= 0) v[a] = 1;
    if (b >= 0) v[b] = 1;
    if (c >= 0) v[c] = 1;
    if (d >= 0) v[d] = 1;
    if (e >= 0) v[e] = 1;
    return v;
  endfunction

  function automatic logic [17:0] expCtrl(input int s, input int op, input bit n);
    if (s == 1) return bitsOf(0, 1, 2, 3, 4) | bitsOf(5, -1, -1, -1, -1);
    if (s == 2) return bitsOf(6, 7, 8, 9, -1);
    if (s == 3) return bitsOf(10, 11, -1, -1, -1);
    case (op)
      0: case (s)
           4: return bitsOf(15, 1, 2, -1, -1);
           5: return bitsOf(14, 8, 9, -1, -1);
           6: return bitsOf(10, 12, 4, 5, -1);
           7: return bitsOf(6, 16, 17, -1, -1);
           default: return '0;
         endcase
      1, 2: begin
        if (s == 4) return bitsOf(13, 12, 4, 5, (op == 2 && !n) ? 17 : -1);
        if (s == 5) return bitsOf(6, 7, (op == 1 || n) ? 17 : -1, -1, -1);
        return '0;
      end
      default: return (s == 4) ? bitsOf(17, -1, -1, -1, -1) : '0;
    endcase
  endfunction

  function automatic string tagFor(input int s, input int op, input bit n);
    if (s == 1) return "R3";
    if (s <= 3) return "R4";
    if (op == 0) return "R6";
    if (op == 1) return "R7";
    if (op == 2) return n ? "R8" : "R9";
    return "R11";
  endfunction

  // model update at the active edge
  always @(posedge clk) begin
    logic [17:0] e;
    e = expCtrl(mStep, int'(opField), negFlag);
    if (rst) begin mStep = 1; mKind = "R1"; end
    else if (e[17]) begin mStep = 1; mKind = "R10"; end
    else if (e[9] && !mfcIn) mKind = "R5";
    else begin
      mStep = (mStep == NS) ? 1 : mStep + 1;
      mKind = (e[9]) ? "R5" : "R2";
    end
  end

  // compare away from the edge, then drive the memory-completed input
  always @(negedge clk) begin
    logic [17:0] eC;
    logic [NS-1:0] eS;
    eC = rst ? '0 : expCtrl(mStep, int'(opField), negFlag);
    eS = rst ? '0 : (NS'(1) << (mStep - 1));
    vecCnt++;
    if (ctrlBus !== eC) begin
      errCnt++;
      $display("FAIL %s ctrlBus step T%0d op %0d: actual %h expected %h",
               rst ? "R1" : tagFor(mStep, int'(opField), negFlag), mStep, opField, ctrlBus, eC);
    end
    vecCnt++;
    if (stepOneHot !== eS) begin
      errCnt++;
      $display("FAIL %s stepOneHot: actual %b expected %b", mKind, stepOneHot, eS);
    end
    if (!rst && eC[9]) begin
      mfcIn = (waitCnt >= latency);
      waitCnt++;
    end else begin
      mfcIn = 0;
      waitCnt = 0;
    end
  end

  task automatic runInstr(input int op, input bit n, input int lat);
    while (mStep != 1) @(negedge clk);
    opField = OW'(op);
    negFlag = n;
    latency = lat;
    @(negedge clk);
    while (mStep != 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    runInstr(0, 0, 0);   // R6 add, immediate completion
    runInstr(0, 1, 3);   // R5 R6 long memory waits
    runInstr(1, 0, 1);   // R7
    runInstr(2, 1, 0);   // R8 flag set
    runInstr(2, 0, 2);   // R9 early end, zIn and endStep together
    runInstr(5, 0, 0);   // R11
    runInstr(15, 1, 0);  // R11
    runInstr(2, 0, 0);   // R9 again back to back
    // R1: reset during a held wait
    opField = OW'(0); latency = 20;
    while (mStep != 2) @(negedge clk);
    repeat (2) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; latency = 0;
    runInstr(1, 1, 0);
    runInstr(0, 0, 1);
    done = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done || cyc > 20000) begin
      if (!done) begin
        errCnt++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule